// File: doc/BRIEF.md
# PLL Divider Parameter Search Engine

This block works out the three integer settings of a frequency synthesizer: the reference divider, the feedback multiplier and the output post divider. Given a reference frequency, a wanted output frequency and an error budget, all in Hz, it tries every combination in a fixed order. It keeps the best combination that meets the phase-detector and VCO window rules. The result is one packed clock-mode word, the output frequency that word actually gives, and a flag that says whether any combination qualified.

A caller drives the three inputs and pulses `start_i`. The engine copies the inputs, holds `busy_o` high while it walks the 1,024 candidates, then pulses `done_o` for one cycle. At that pulse the results appear, and they stay put until the next accepted start. Each candidate is evaluated in turn on one shared multicycle multiplier and one shared restoring divider. Candidates that fail an early check are dropped before the remaining arithmetic runs.

Top module: `pll_param_search`

## Requirements
- R1: A `start_i` pulse seen while idle latches `fin_i`, `ftgt_i` and `ferr_i` and raises `busy_o` on the next cycle. `done_o` is a one-cycle pulse issued as `busy_o` falls. A `start_i` that arrives while busy has no effect on the result.
- R2: Post index k runs from 0 to 15 in the outer loop; the post divide is 1 for k=0 and 2k otherwise. The reference divider d runs from 64 down to 1 in the inner loop. A candidate whose error equals the best so far replaces it, so for 20 MHz to 100 MHz with zero error the result is d=1, mult=10, post=2 (mode 0x01000903).
- R3: Every quotient is rounded half up, computed as (2·dividend / divisor + 1) >> 1. The three quotients are Fpfd = round(fin/d), mult = round(target·post/Fpfd) and fout = round(Fpfd·mult/post).
- R4: A candidate is rejected if Fpfd < 250,000, mult > 1024 or Fpfd·mult < 99,000,000. For 20 MHz to 60 MHz with zero error, post 1 fails the VCO floor and the result is mode 0x01000503.
- R5: A candidate with Fpfd·mult above 201,000,000 is rejected unless Fpfd·mult ≤ target + allowed error. So 20 MHz to 250 MHz with zero error gives mode 0x010418F3.
- R6: The best error starts at the allowed error, and a candidate is accepted only when |fout − target| is no more than the best error so far.
- R7: Mode word layout:
  - bit 24 = 1;
  - bits 23:18 = d−1;
  - bits 17:8 = mult−1;
  - bits 7:4 = (k−1) mod 16, so divide-by-1 is 1111;
  - bits 3:2 = 00;
  - bits 1:0 = 11;
  - bits 31:25 = 0.
- R8: `found_o` is 1 at done exactly when at least one candidate was accepted. A 100 kHz reference can never reach the phase-detector floor and yields `found_o` = 0. `found_o`, `mode_o` and `freq_o` change only in the cycle `done_o` is high.
- R9: `freq_o` equals the rounded output frequency fout of the accepted candidate that was kept.
- R10: After reset `busy_o`, `done_o`, `found_o`, `mode_o` and `freq_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted when idle |
| fin_i | input | 32 | Reference frequency in Hz |
| ftgt_i | input | 32 | Wanted output frequency in Hz |
| ferr_i | input | 32 | Allowed absolute error in Hz |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle completion pulse |
| found_o | output | 1 | A qualifying setting was found |
| mode_o | output | 32 | Packed clock-mode word |
| freq_o | output | 32 | Output frequency given by mode_o |

## Verification
The bound checks on the found result compare `freq_o` against `ftgt_i` and `ferr_i` at the done pulse. They therefore assume the target and error inputs are held steady from start until done, and that target plus error fits below 2^32 so the reported frequency does not wrap. The stimulus keeps target and error constant across every search. When it exercises the ignored-start case, it changes only the reference frequency and restores it in the following cycle. All frequencies are chosen so that no intermediate product exceeds its stated width.

// File: rtl/pllsrch_pkg.sv
package pllsrch_pkg;

    localparam int unsigned FW     = 32;   // frequency port width
    localparam int unsigned DW     = 48;   // wide datapath width
    localparam int unsigned MBW    = 11;   // multiplier operand width
    localparam int unsigned DIVD_W = 7;
    localparam int unsigned IDX_W  = 4;
    localparam int unsigned POST_W = 5;

    localparam logic [DIVD_W-1:0] DIVD_FIRST = 7'd64;
    localparam logic [IDX_W-1:0]  IDX_LAST   = 4'd15;

    localparam logic [DW-1:0] PFD_MIN  = 48'd250_000;
    localparam logic [DW-1:0] MULT_MAX = 48'd1024;
    localparam logic [DW-1:0] VCO_MIN  = 48'd99_000_000;
    localparam logic [DW-1:0] VCO_MAX  = 48'd201_000_000;

    typedef enum logic [3:0] {
        S_IDLE, S_LAUNCH, S_PFD, S_TGT, S_MULT, S_VCO, S_OUT, S_EVAL, S_NEXT
    } srch_state_e;

    function automatic logic [DW-1:0] round_half(input logic [DW-1:0] q);
        logic [DW-1:0] s;
        s = q + 1'b1;
        return s >> 1;
    endfunction

    function automatic logic [FW-1:0] pack_mode(input logic [IDX_W-1:0]  idx,
                                                input logic [DIVD_W-1:0] divd,
                                                input logic [MBW-1:0]    mult);
        logic [DIVD_W-1:0] dm1;
        logic [MBW-1:0]    mm1;
        logic [IDX_W-1:0]  pm1;
        dm1 = divd - 1'b1;
        mm1 = mult - 1'b1;
        pm1 = idx - 1'b1;
        return {7'd0, 1'b1, dm1[5:0], mm1[9:0], pm1, 2'b00, 2'b11};
    endfunction

endpackage

// File: rtl/pllsrch_div.sv
module pllsrch_div #(
    parameter int unsigned DW  = 48,
    parameter int unsigned VW  = 32,
    parameter int unsigned BPC = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go_i,
    input  logic [DW-1:0] dnd_i,
    input  logic [VW-1:0] dsr_i,
    output logic          done_o,
    output logic [DW-1:0] quo_o
);
    localparam int unsigned STEPS = (DW + BPC - 1) / BPC;
    localparam int unsigned CW    = $clog2(STEPS + 1);

    typedef struct packed {
        logic          busy;
        logic          done;
        logic [CW-1:0] cnt;
        logic [VW:0]   rem;
        logic [DW-1:0] quo;
        logic [VW-1:0] dsr;
    } div_st_t;

    div_st_t st_d, st_q;
    logic [VW:0]   r_w;
    logic [DW-1:0] q_w;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        r_w       = st_q.rem;
        q_w       = st_q.quo;
        if (go_i) begin
            st_d.busy = 1'b1;
            st_d.cnt  = CW'(STEPS);
            st_d.rem  = '0;
            st_d.quo  = dnd_i;
            st_d.dsr  = dsr_i;
        end else if (st_q.busy) begin
            for (int i = 0; i < BPC; i++) begin
                r_w = {r_w[VW-1:0], q_w[DW-1]};
                q_w = {q_w[DW-2:0], 1'b0};
                if (r_w >= {1'b0, st_q.dsr}) begin
                    r_w    = r_w - {1'b0, st_q.dsr};
                    q_w[0] = 1'b1;
                end
            end
            st_d.rem = r_w;
            st_d.quo = q_w;
            st_d.cnt = st_q.cnt - 1'b1;
            if (st_q.cnt == CW'(1)) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done_o = st_q.done;
    assign quo_o  = st_q.quo;

endmodule

// File: rtl/pllsrch_mul.sv
module pllsrch_mul #(
    parameter int unsigned AW  = 48,
    parameter int unsigned BW  = 11,
    parameter int unsigned BPC = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go_i,
    input  logic [AW-1:0] a_i,
    input  logic [BW-1:0] b_i,
    output logic          done_o,
    output logic [AW-1:0] prod_o
);
    localparam int unsigned STEPS = (BW + BPC - 1) / BPC;
    localparam int unsigned CW    = $clog2(STEPS + 1);

    typedef struct packed {
        logic          busy;
        logic          done;
        logic [CW-1:0] cnt;
        logic [AW-1:0] acc;
        logic [AW-1:0] a;
        logic [BW-1:0] b;
    } mul_st_t;

    mul_st_t st_d, st_q;
    logic [AW-1:0] acc_w, a_w;
    logic [BW-1:0] b_w;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        acc_w     = st_q.acc;
        a_w       = st_q.a;
        b_w       = st_q.b;
        if (go_i) begin
            st_d.busy = 1'b1;
            st_d.cnt  = CW'(STEPS);
            st_d.acc  = '0;
            st_d.a    = a_i;
            st_d.b    = b_i;
        end else if (st_q.busy) begin
            for (int i = 0; i < BPC; i++) begin
                if (b_w[0]) acc_w = acc_w + a_w;
                a_w = {a_w[AW-2:0], 1'b0};
                b_w = b_w >> 1;
            end
            st_d.acc = acc_w;
            st_d.a   = a_w;
            st_d.b   = b_w;
            st_d.cnt = st_q.cnt - 1'b1;
            if (st_q.cnt == CW'(1)) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done_o = st_q.done;
    assign prod_o = st_q.acc;

endmodule

// File: rtl/pllsrch_eval.sv
module pllsrch_eval
    import pllsrch_pkg::*;
(
    input  logic [DW-1:0] fpfd_i,
    input  logic [DW-1:0] mult_i,
    input  logic [DW-1:0] fvco_i,
    input  logic [DW-1:0] fout_i,
    input  logic [FW-1:0] tgt_i,
    input  logic [FW-1:0] lerr_i,
    input  logic [DW-1:0] best_i,
    output logic          accept_o,
    output logic [DW-1:0] err_o
);
    logic [DW-1:0] tgt_w, ceil_w;
    logic          win_lo, win_hi;

    always_comb begin
        tgt_w  = DW'(tgt_i);
        ceil_w = DW'(tgt_i) + DW'(lerr_i);
        err_o  = (fout_i >= tgt_w) ? (fout_i - tgt_w) : (tgt_w - fout_i);
        win_lo = (fpfd_i >= PFD_MIN) && (mult_i <= MULT_MAX) && (fvco_i >= VCO_MIN);
        win_hi = (fvco_i <= VCO_MAX) || (fvco_i <= ceil_w);
        accept_o = win_lo && win_hi && (err_o <= best_i);
    end

endmodule

// File: rtl/pll_param_search.sv
module pll_param_search
    import pllsrch_pkg::*;
#(
    parameter int unsigned DIV_BPC = 16,
    parameter int unsigned MUL_BPC = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [31:0]   fin_i,
    input  logic [31:0]   ftgt_i,
    input  logic [31:0]   ferr_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          found_o,
    output logic [31:0]   mode_o,
    output logic [31:0]   freq_o
);
    typedef struct packed {
        srch_state_e       state;
        logic              busy;
        logic              done;
        logic [FW-1:0]     fin;
        logic [FW-1:0]     tgt;
        logic [FW-1:0]     lerr;
        logic [IDX_W-1:0]  idx;
        logic [DIVD_W-1:0] divd;
        logic [POST_W-1:0] post;
        logic [DW-1:0]     fpfd;
        logic [DW-1:0]     mult;
        logic [DW-1:0]     fvco;
        logic [DW-1:0]     fout;
        logic [DW-1:0]     best_err;
        logic              best_found;
        logic [FW-1:0]     best_mode;
        logic [FW-1:0]     best_freq;
        logic              out_found;
        logic [FW-1:0]     out_mode;
        logic [FW-1:0]     out_freq;
        logic              div_go;
        logic [DW-1:0]     div_dnd;
        logic [FW-1:0]     div_dsr;
        logic              mul_go;
        logic [DW-1:0]     mul_a;
        logic [MBW-1:0]    mul_b;
    } top_st_t;

    top_st_t st_d, st_q;

    logic          div_done_w, mul_done_w, accept_w;
    logic [DW-1:0] div_q_w, mul_p_w, err_w, rq_w;

    pllsrch_div #(.DW(DW), .VW(FW), .BPC(DIV_BPC)) u_div (
        .clk(clk), .rst_n(rst_n), .go_i(st_q.div_go), .dnd_i(st_q.div_dnd),
        .dsr_i(st_q.div_dsr), .done_o(div_done_w), .quo_o(div_q_w)
    );

    pllsrch_mul #(.AW(DW), .BW(MBW), .BPC(MUL_BPC)) u_mul (
        .clk(clk), .rst_n(rst_n), .go_i(st_q.mul_go), .a_i(st_q.mul_a),
        .b_i(st_q.mul_b), .done_o(mul_done_w), .prod_o(mul_p_w)
    );

    pllsrch_eval u_eval (
        .fpfd_i(st_q.fpfd), .mult_i(st_q.mult), .fvco_i(st_q.fvco),
        .fout_i(st_q.fout), .tgt_i(st_q.tgt), .lerr_i(st_q.lerr),
        .best_i(st_q.best_err), .accept_o(accept_w), .err_o(err_w)
    );

    assign rq_w = round_half(div_q_w);

    always_comb begin
        st_d        = st_q;
        st_d.done   = 1'b0;
        st_d.div_go = 1'b0;
        st_d.mul_go = 1'b0;
        unique case (st_q.state)
            S_IDLE: begin
                if (start_i) begin
                    st_d.fin        = fin_i;
                    st_d.tgt        = ftgt_i;
                    st_d.lerr       = ferr_i;
                    st_d.idx        = '0;
                    st_d.post       = POST_W'(1);
                    st_d.divd       = DIVD_FIRST;
                    st_d.best_err   = DW'(ferr_i);
                    st_d.best_found = 1'b0;
                    st_d.busy       = 1'b1;
                    st_d.state      = S_LAUNCH;
                end
            end
            S_LAUNCH: begin
                st_d.div_go  = 1'b1;
                st_d.div_dnd = {DW'(st_q.fin)} << 1;
                st_d.div_dsr = FW'(st_q.divd);
                st_d.state   = S_PFD;
            end
            S_PFD: begin
                if (div_done_w) begin
                    st_d.fpfd = rq_w;
                    if (rq_w < PFD_MIN) begin
                        st_d.state = S_NEXT;
                    end else begin
                        st_d.mul_go = 1'b1;
                        st_d.mul_a  = {DW'(st_q.tgt)} << 1;
                        st_d.mul_b  = MBW'(st_q.post);
                        st_d.state  = S_TGT;
                    end
                end
            end
            S_TGT: begin
                if (mul_done_w) begin
                    st_d.div_go  = 1'b1;
                    st_d.div_dnd = mul_p_w;
                    st_d.div_dsr = st_q.fpfd[FW-1:0];
                    st_d.state   = S_MULT;
                end
            end
            S_MULT: begin
                if (div_done_w) begin
                    st_d.mult = rq_w;
                    if (rq_w > MULT_MAX) begin
                        st_d.state = S_NEXT;
                    end else begin
                        st_d.mul_go = 1'b1;
                        st_d.mul_a  = st_q.fpfd;
                        st_d.mul_b  = rq_w[MBW-1:0];
                        st_d.state  = S_VCO;
                    end
                end
            end
            S_VCO: begin
                if (mul_done_w) begin
                    st_d.fvco    = mul_p_w;
                    st_d.div_go  = 1'b1;
                    st_d.div_dnd = mul_p_w << 1;
                    st_d.div_dsr = FW'(st_q.post);
                    st_d.state   = S_OUT;
                end
            end
            S_OUT: begin
                if (div_done_w) begin
                    st_d.fout  = rq_w;
                    st_d.state = S_EVAL;
                end
            end
            S_EVAL: begin
                if (accept_w) begin
                    st_d.best_err   = err_w;
                    st_d.best_found = 1'b1;
                    st_d.best_mode  = pack_mode(st_q.idx, st_q.divd, st_q.mult[MBW-1:0]);
                    st_d.best_freq  = st_q.fout[FW-1:0];
                end
                st_d.state = S_NEXT;
            end
            S_NEXT: begin
                if (st_q.divd != DIVD_W'(1)) begin
                    st_d.divd  = st_q.divd - 1'b1;
                    st_d.state = S_LAUNCH;
                end else if (st_q.idx != IDX_LAST) begin
                    st_d.idx   = st_q.idx + 1'b1;
                    st_d.post  = {st_d.idx, 1'b0};
                    st_d.divd  = DIVD_FIRST;
                    st_d.state = S_LAUNCH;
                end else begin
                    st_d.out_found = st_q.best_found;
                    st_d.out_mode  = st_q.best_mode;
                    st_d.out_freq  = st_q.best_freq;
                    st_d.done      = 1'b1;
                    st_d.busy      = 1'b0;
                    st_d.state     = S_IDLE;
                end
            end
            default: st_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.state <= S_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o  = st_q.busy;
    assign done_o  = st_q.done;
    assign found_o = st_q.out_found;
    assign mode_o  = st_q.out_mode;
    assign freq_o  = st_q.out_freq;

endmodule

// File: rtl/pll_param_search_chk.sv
module pll_param_search_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic [31:0] ftgt_i,
    input logic [31:0] ferr_i,
    input logic        busy_o,
    input logic        done_o,
    input logic        found_o,
    input logic [31:0] mode_o,
    input logic [31:0] freq_o
);
    logic [32:0] dev_w;
    assign dev_w = (freq_o >= ftgt_i) ? {1'b0, freq_o - ftgt_i} : {1'b0, ftgt_i - freq_o};

    a_r1_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && !done_o) |=> busy_o);

    a_r1_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r1_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    a_r1_busy_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    a_r7_mode_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && found_o) |-> (mode_o[31:25] == 7'd0 && mode_o[24] && mode_o[3:0] == 4'b0011));

    a_r6_freq_within_error: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && found_o) |-> (dev_w <= {1'b0, ferr_i}));

    a_r8_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(found_o) && $stable(mode_o) && $stable(freq_o)));

endmodule

bind pll_param_search pll_param_search_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ftgt_i(ftgt_i), .ferr_i(ferr_i),
    .busy_o(busy_o), .done_o(done_o), .found_o(found_o), .mode_o(mode_o), .freq_o(freq_o)
);

// File: tb/pll_param_search_tb.sv
module pll_param_search_tb;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [31:0] mode;
        logic [31:0] freq;
        logic        found;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] fin_i = '0, ftgt_i = '0, ferr_i = '0;
    logic        busy_o, done_o, found_o;
    logic [31:0] mode_o, freq_o;

    int checks = 0;
    int fails  = 0;
    exp_t exp_q[$];
    exp_t last_exp;
    bit   finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pll_param_search u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .fin_i(fin_i),
        .ftgt_i(ftgt_i), .ferr_i(ferr_i), .busy_o(busy_o), .done_o(done_o),
        .found_o(found_o), .mode_o(mode_o), .freq_o(freq_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint unsigned act, input longint unsigned exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // Independent model of the search from the requirements (R2 to R7, R9)
    function automatic exp_t ref_search(input logic [31:0] fin, input logic [31:0] tgt,
                                        input logic [31:0] aerr);
        exp_t r;
        longint unsigned best, pf, ml, vco, fo, e, post, f, t, ae, dd;
        r.found = 1'b0; r.mode = '0; r.freq = '0; r.req = "";
        f = longint'(fin); t = longint'(tgt); ae = longint'(aerr);
        best = ae;
        for (int k = 0; k < 16; k++) begin
            post = (k == 0) ? 1 : 2 * k;
            for (int d = 64; d >= 1; d--) begin
                dd = longint'(d);
                pf = ((2 * f) / dd + 1) >> 1;
                if (pf < 250000) continue;
                ml = ((2 * t * post) / pf + 1) >> 1;
                if (ml > 1024) continue;
                vco = pf * ml;
                fo  = ((2 * vco) / post + 1) >> 1;
                e   = (fo >= t) ? fo - t : t - fo;
                if (e <= best && vco >= 99000000 && (vco <= 201000000 || vco <= t + ae)) begin
                    best    = e;
                    r.found = 1'b1;
                    r.mode  = {7'd0, 1'b1, 6'(d - 1), 10'(ml - 1), 4'(k - 1), 4'b0011};
                    r.freq  = fo[31:0];
                end
            end
        end
        return r;
    endfunction

    // Driver: push expected item, start search, wait until monitor consumed it
    task automatic run_case(input logic [31:0] fin, input logic [31:0] tgt,
                            input logic [31:0] aerr, input string req, input bit poke);
        exp_t e;
        e = ref_search(fin, tgt, aerr);
        e.req = req;
        exp_q.push_back(e);
        @(negedge clk);
        fin_i = fin; ftgt_i = tgt; ferr_i = aerr; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o === 1'b1, "R1", "busy after start", busy_o, 1);
        if (poke) begin
            repeat (40) @(negedge clk);
            fin_i = fin + 32'd3_000_000; start_i = 1'b1;   // R1: must be ignored
            @(negedge clk);
            start_i = 1'b0; fin_i = fin;
        end
        wait (exp_q.size() == 0);
        @(negedge clk);
    endtask

    // Monitor: compare results at done
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (rst_n && done_o) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R1", "unexpected done", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    last_exp = e;
                    chk(busy_o === 1'b0, "R1", "busy low at done", busy_o, 0);
                    chk(found_o === e.found, {e.req, " R8"}, "found", found_o, e.found);
                    if (e.found) begin
                        chk(mode_o === e.mode, {e.req, " R7"}, "mode", mode_o, e.mode);
                        chk(freq_o === e.freq, {e.req, " R9"}, "freq", freq_o, e.freq);
                    end
                    @(negedge clk);
                    chk(done_o === 1'b0, "R1", "done one cycle", done_o, 0);
                end
            end
        end
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!finished) begin
            chk(1'b0, "WATCHDOG", "timeout", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(busy_o === 1'b0, "R10", "busy reset", busy_o, 0);
        chk(done_o === 1'b0, "R10", "done reset", done_o, 0);
        chk(found_o === 1'b0, "R10", "found reset", found_o, 0);
        chk(mode_o === 32'd0, "R10", "mode reset", mode_o, 0);
        chk(freq_o === 32'd0, "R10", "freq reset", freq_o, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 tie breaking: smaller divider and later post index win
        run_case(32'd20_000_000, 32'd100_000_000, 32'd0, "R2", 1'b0);
        chk(mode_o === 32'h0100_0903, "R2", "tie winner mode", mode_o, 32'h0100_0903);

        // R5 VCO above 201 MHz allowed up to target plus error; R1 ignored start
        run_case(32'd20_000_000, 32'd250_000_000, 32'd0, "R5", 1'b1);
        chk(mode_o === 32'h0104_18F3, "R5", "vco ceiling mode", mode_o, 32'h0104_18F3);
        chk(freq_o === 32'd250_000_000, "R1", "ignored start result", freq_o, 250_000_000);

        // R4 VCO floor rejects post 1
        run_case(32'd20_000_000, 32'd60_000_000, 32'd0, "R4", 1'b0);
        chk(mode_o === 32'h0100_0503, "R4", "vco floor mode", mode_o, 32'h0100_0503);
        chk(freq_o === 32'd60_000_000, "R9", "vco floor freq", freq_o, 60_000_000);

        // R3 rounding and R6 error budget on a non-exact target
        run_case(32'd12_000_000, 32'd148_500_000, 32'd100, "R3 R6", 1'b0);

        // R4 phase-detector floor: no candidate qualifies, found low (R8)
        run_case(32'd100_000, 32'd100_000_000, 32'd1_000_000, "R4", 1'b0);
        chk(found_o === 1'b0, "R8", "nothing found", found_o, 0);

        // R5 high target with a low reference
        run_case(32'd4_000_000, 32'd320_000_000, 32'd0, "R5", 1'b0);

        // R8 outputs hold after done
        repeat (30) @(negedge clk);
        chk(found_o === last_exp.found, "R8", "found held", found_o, last_exp.found);
        chk(mode_o === last_exp.mode, "R8", "mode held", mode_o, last_exp.mode);
        chk(freq_o === last_exp.freq, "R8", "freq held", freq_o, last_exp.freq);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule